// File: doc/BRIEF.md
# Video Controller Host Register Port

This block is the processor-facing side of a tile-based video controller. A byte-wide bus with two address bits reaches a file of 16-bit configuration registers. The processor first writes an index into a select latch. It then writes the low and high bytes of the chosen register through two data ports. Writing the high byte is what acts on the register. That write can store a word to video memory, start a prefetch from video memory, or request a transfer from a separate DMA engine.

Video memory is reached through a word read/write interface. Memory reads return one cycle after the request. The port prefetches each read word into a buffer, so the processor sees it with no wait on the next access. After every memory access the write and read addresses step forward by a stride that software selects. A status byte gathers event flags raised by other parts of the controller. Reading the status byte returns it, clears it and drops the interrupt line.

The scroll and display-geometry registers are brought out as outputs for the rendering logic.

Top module: `vidctl_host_port`

## Requirements
- R1: A write to port 0 loads the register index from bits 4:0 of the data. A write to port 2 replaces bits 7:0 of the indexed register. A write to port 3 replaces bits 15:8 of the indexed register. In both cases the other byte keeps its value.
- R2: After reset, register 10 is 0x00FF, register 11 is 0x001F, register 13 is 0x01FF, and registers 12 and 14 are 0xFFFF. The read buffer is 0xFFFF and the status byte is 0 with the interrupt low.
- R3: Bits 12:11 of register 5 set the address stride: 0 gives 1, 1 gives 32, 2 gives 64 and 3 gives 128.
- R4: A port 3 write while the index is 2 stores the word {written byte, register 2 bits 7:0} to video memory at the address in register 0. It then adds the stride to register 0.
- R5: If register 0 is 0x8000 or above, that store is suppressed, but register 0 still advances.
- R6: A port 3 write while the index is 1 fetches video memory at the new register 1 value taken modulo 0x8000. The fetched word goes into the read buffer.
- R7: A port 2 read returns bits 7:0 of the read buffer and has no side effect. A port 3 read returns bits 15:8. If the index is 2, the port 3 read also adds the stride to register 1 and prefetches the word at the new address. With any other index, the port 3 read leaves register 1 alone.
- R8: A port 0 read returns the status byte, clears it and drops the interrupt. A port 1 read returns 0.
- R9: Input event bit i sets status bit i and raises the interrupt. Bit 5 is vertical blank, bit 4 is memory-to-memory DMA done, bit 3 is sprite-table DMA done, bit 2 is raster match, bit 1 is sprite overflow and bit 0 is sprite-0 collision. Status bits 7:6 read as 0.
- R10: Writes to register 7 (horizontal scroll) keep only bits 9:0. Writes to register 8 (vertical scroll) keep only bits 8:0.
- R11: A port 3 write to register 18 gives a one-cycle memory DMA request on the next cycle. A port 3 write to register 19 does the same for a sprite-table DMA request. Port 2 writes to either register give no request.
- R12: In the cycle after a video memory read is issued, `cpu_ready` is low and no bus access is taken. The prefetched word is in the buffer when `cpu_ready` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Bus access strobe |
| cpu_wr | input | 1 | Access is a write |
| cpu_rd | input | 1 | Access is a read |
| cpu_addr | input | 2 | Port number |
| cpu_wdata | input | 8 | Write data byte |
| cpu_rdata | output | 8 | Read data byte for the addressed port |
| cpu_ready | output | 1 | Access is accepted this cycle |
| evt_set | input | 6 | Status event set pulses |
| irq | output | 1 | Interrupt request |
| vram_addr | output | 15 | Video memory word address |
| vram_we | output | 1 | Video memory write strobe |
| vram_re | output | 1 | Video memory read strobe (data returns one cycle later) |
| vram_wdata | output | 16 | Video memory write word |
| vram_rdata | input | 16 | Video memory read word |
| dma_vram_req | output | 1 | Memory-to-memory DMA start pulse |
| dma_spr_req | output | 1 | Sprite-table DMA start pulse |
| hscroll_cfg | output | 16 | Register 7 |
| vscroll_cfg | output | 16 | Register 8 |
| hsync_cfg | output | 16 | Register 10 |
| hdisp_cfg | output | 16 | Register 11 |
| vsync_cfg | output | 16 | Register 12 |
| vdisp_cfg | output | 16 | Register 13 |
| vend_cfg | output | 16 | Register 14 |

## Verification
The bench builds the block with its default parameters: a 15-bit video memory address and a 5-bit register index. With a 15-bit address, the 0x8000 boundary is reached by setting register 0 to 0x7FFF and stepping once. This lets one test show both the last stored word and the suppressed store that follows it. A 5-bit index reaches every register the port acts on, including both DMA triggers. The bench memory model decodes only the low 10 address bits, so the chosen test addresses differ in those bits.

// File: rtl/vhp_pkg.sv
package vhp_pkg;

  localparam int STAT_W      = 6;
  localparam int RI_WADDR    = 0;
  localparam int RI_RADDR    = 1;
  localparam int RI_DATA     = 2;
  localparam int RI_CTRL     = 5;
  localparam int RI_HSCROLL  = 7;
  localparam int RI_VSCROLL  = 8;
  localparam int RI_HSYNC    = 10;
  localparam int RI_HDISP    = 11;
  localparam int RI_VSYNC    = 12;
  localparam int RI_VDISP    = 13;
  localparam int RI_VEND     = 14;
  localparam int RI_DMA_LEN  = 18;
  localparam int RI_SPR_BASE = 19;

  typedef enum logic [1:0] {
    PORT_SEL  = 2'd0,
    PORT_NONE = 2'd1,
    PORT_LO   = 2'd2,
    PORT_HI   = 2'd3
  } port_e;

  // Address stride picked by control register bits 12:11.
  function automatic logic [15:0] stride_of(logic [15:0] ctrl);
    case (ctrl[12:11])
      2'd0:    return 16'd1;
      2'd1:    return 16'd32;
      2'd2:    return 16'd64;
      default: return 16'd128;
    endcase
  endfunction

  function automatic logic [15:0] reset_value(int idx);
    case (idx)
      RI_HSYNC: return 16'h00FF;
      RI_HDISP: return 16'h001F;
      RI_VSYNC: return 16'hFFFF;
      RI_VDISP: return 16'h01FF;
      RI_VEND:  return 16'hFFFF;
      default:  return 16'h0000;
    endcase
  endfunction

  // Bits that a register actually stores.
  function automatic logic [15:0] field_mask(int idx);
    case (idx)
      RI_HSCROLL: return 16'h03FF;
      RI_VSCROLL: return 16'h01FF;
      default:    return 16'hFFFF;
    endcase
  endfunction

endpackage

// File: rtl/vhp_regfile.sv
module vhp_regfile
  import vhp_pkg::*;
#(
  parameter int REG_IDX_W = 5,
  localparam int REG_CNT  = 1 << REG_IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_lo,
  input  logic                 wr_hi,
  input  logic [REG_IDX_W-1:0] idx,
  input  logic [7:0]           bdata,
  input  logic                 inc_waddr,
  input  logic                 inc_raddr,
  input  logic [15:0]          stride,
  output logic [15:0]          regs_o [REG_CNT]
);

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    localparam logic [15:0] RST = reset_value(g);
    localparam logic [15:0] MSK = field_mask(g);
    logic [15:0] q;
    logic        hit;
    logic        bump;

    assign hit  = (idx == REG_IDX_W'(g));
    assign bump = (g == RI_WADDR) ? inc_waddr :
                  (g == RI_RADDR) ? inc_raddr : 1'b0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             q <= RST;
      else if (hit && wr_lo)  q <= {q[15:8], bdata} & MSK;
      else if (hit && wr_hi)  q <= {bdata, q[7:0]} & MSK;
      else if (bump)          q <= q + stride;
    end

    assign regs_o[g] = q;
  end

endmodule

// File: rtl/vhp_vram_port.sv
module vhp_vram_port #(
  parameter int VRAM_AW = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_data,
  input  logic               commit_raddr,
  input  logic               advance_read,
  input  logic [7:0]         bdata,
  input  logic [15:0]        waddr,
  input  logic [15:0]        raddr,
  input  logic [15:0]        data_reg,
  input  logic [15:0]        stride,
  output logic [VRAM_AW-1:0] vram_addr,
  output logic               vram_we,
  output logic               vram_re,
  output logic [15:0]        vram_wdata,
  input  logic [15:0]        vram_rdata,
  output logic [15:0]        rbuf,
  output logic               busy
);

  logic [15:0] raddr_new;
  logic [15:0] raddr_next;
  logic        waddr_in_range;

  assign raddr_new      = {bdata, raddr[7:0]};
  assign raddr_next     = raddr + stride;
  assign waddr_in_range = (waddr[15:VRAM_AW] == '0);
  assign vram_wdata     = {bdata, data_reg[7:0]};

  always_comb begin
    vram_addr = '0;
    vram_we   = 1'b0;
    vram_re   = 1'b0;
    if (commit_data) begin
      vram_addr = waddr[VRAM_AW-1:0];
      vram_we   = waddr_in_range;
    end else if (commit_raddr) begin
      vram_addr = raddr_new[VRAM_AW-1:0];
      vram_re   = 1'b1;
    end else if (advance_read) begin
      vram_addr = raddr_next[VRAM_AW-1:0];
      vram_re   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      rbuf <= 16'hFFFF;
    end else begin
      busy <= vram_re;
      if (busy) rbuf <= vram_rdata;
    end
  end

endmodule

// File: rtl/vhp_status.sv
module vhp_status
  import vhp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] evt_set,
  input  logic              clr,
  output logic [7:0]        status_byte,
  output logic              irq
);

  logic [STAT_W-1:0] flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (clr ? '0 : flags) | evt_set;
      irq   <= (clr ? 1'b0 : irq) | (|evt_set);
    end
  end

  assign status_byte = {{(8 - STAT_W){1'b0}}, flags};

endmodule

// File: rtl/vidctl_host_port.sv
module vidctl_host_port
  import vhp_pkg::*;
#(
  parameter int VRAM_AW   = 15,
  parameter int REG_IDX_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_sel,
  input  logic               cpu_wr,
  input  logic               cpu_rd,
  input  logic [1:0]         cpu_addr,
  input  logic [7:0]         cpu_wdata,
  output logic [7:0]         cpu_rdata,
  output logic               cpu_ready,
  input  logic [5:0]         evt_set,
  output logic               irq,
  output logic [VRAM_AW-1:0] vram_addr,
  output logic               vram_we,
  output logic               vram_re,
  output logic [15:0]        vram_wdata,
  input  logic [15:0]        vram_rdata,
  output logic               dma_vram_req,
  output logic               dma_spr_req,
  output logic [15:0]        hscroll_cfg,
  output logic [15:0]        vscroll_cfg,
  output logic [15:0]        hsync_cfg,
  output logic [15:0]        hdisp_cfg,
  output logic [15:0]        vsync_cfg,
  output logic [15:0]        vdisp_cfg,
  output logic [15:0]        vend_cfg
);

  localparam int REG_CNT = 1 << REG_IDX_W;

  logic [REG_IDX_W-1:0] idx_q;
  logic [15:0]          regs [REG_CNT];
  logic [15:0]          rbuf;
  logic [7:0]           status_byte;
  logic                 busy;
  port_e                port;

  // Named internal events.
  logic acc_wr, acc_rd;
  logic wr_sel, wr_lo, wr_hi;
  logic commit_data, commit_raddr, advance_read, stat_rd;
  logic commit_len, commit_spr;
  logic [15:0] stride, waddr_q, raddr_q;

  assign port         = port_e'(cpu_addr);
  assign cpu_ready    = ~busy;
  assign acc_wr       = cpu_sel & ~busy & cpu_wr;
  assign acc_rd       = cpu_sel & ~busy & cpu_rd & ~cpu_wr;
  assign wr_sel       = acc_wr && (port == PORT_SEL);
  assign wr_lo        = acc_wr && (port == PORT_LO);
  assign wr_hi        = acc_wr && (port == PORT_HI);
  assign commit_data  = wr_hi && (idx_q == REG_IDX_W'(RI_DATA));
  assign commit_raddr = wr_hi && (idx_q == REG_IDX_W'(RI_RADDR));
  assign commit_len   = wr_hi && (idx_q == REG_IDX_W'(RI_DMA_LEN));
  assign commit_spr   = wr_hi && (idx_q == REG_IDX_W'(RI_SPR_BASE));
  assign advance_read = acc_rd && (port == PORT_HI) && (idx_q == REG_IDX_W'(RI_DATA));
  assign stat_rd      = acc_rd && (port == PORT_SEL);

  assign stride  = stride_of(regs[RI_CTRL]);
  assign waddr_q = regs[RI_WADDR];
  assign raddr_q = regs[RI_RADDR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q        <= '0;
      dma_vram_req <= 1'b0;
      dma_spr_req  <= 1'b0;
    end else begin
      if (wr_sel) idx_q <= cpu_wdata[REG_IDX_W-1:0];
      dma_vram_req <= commit_len;
      dma_spr_req  <= commit_spr;
    end
  end

  vhp_regfile #(.REG_IDX_W(REG_IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .idx       (idx_q),
    .bdata     (cpu_wdata),
    .inc_waddr (commit_data),
    .inc_raddr (advance_read),
    .stride    (stride),
    .regs_o    (regs)
  );

  vhp_vram_port #(.VRAM_AW(VRAM_AW)) u_vram (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit_data  (commit_data),
    .commit_raddr (commit_raddr),
    .advance_read (advance_read),
    .bdata        (cpu_wdata),
    .waddr        (waddr_q),
    .raddr        (raddr_q),
    .data_reg     (regs[RI_DATA]),
    .stride       (stride),
    .vram_addr    (vram_addr),
    .vram_we      (vram_we),
    .vram_re      (vram_re),
    .vram_wdata   (vram_wdata),
    .vram_rdata   (vram_rdata),
    .rbuf         (rbuf),
    .busy         (busy)
  );

  vhp_status u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_set     (evt_set),
    .clr         (stat_rd),
    .status_byte (status_byte),
    .irq         (irq)
  );

  always_comb begin
    case (port)
      PORT_SEL:  cpu_rdata = status_byte;
      PORT_LO:   cpu_rdata = rbuf[7:0];
      PORT_HI:   cpu_rdata = rbuf[15:8];
      default:   cpu_rdata = 8'h00;
    endcase
  end

  assign hscroll_cfg = regs[RI_HSCROLL];
  assign vscroll_cfg = regs[RI_VSCROLL];
  assign hsync_cfg   = regs[RI_HSYNC];
  assign hdisp_cfg   = regs[RI_HDISP];
  assign vsync_cfg   = regs[RI_VSYNC];
  assign vdisp_cfg   = regs[RI_VDISP];
  assign vend_cfg    = regs[RI_VEND];

endmodule

// File: rtl/vhp_checker.sv
module vhp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        commit_data,
  input logic        advance_read,
  input logic        stat_rd,
  input logic        commit_len,
  input logic        commit_spr,
  input logic [5:0]  evt_set,
  input logic [15:0] waddr_q,
  input logic [15:0] raddr_q,
  input logic [15:0] stride,
  input logic [7:0]  status_byte,
  input logic        irq,
  input logic        vram_we,
  input logic        vram_re,
  input logic        cpu_ready,
  input logic        dma_vram_req,
  input logic        dma_spr_req
);

  a_r4_write_steps: assert property (@(posedge clk) disable iff (!rst_n)
    commit_data |=> waddr_q == $past(waddr_q + stride));

  a_r7_read_steps: assert property (@(posedge clk) disable iff (!rst_n)
    advance_read |=> raddr_q == $past(raddr_q + stride));

  a_r8_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && evt_set == 6'd0) |=> (status_byte == 8'd0 && !irq));

  a_r9_event_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != 6'd0) |=> irq);

  a_r11_len_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dma_vram_req |-> $past(commit_len));

  a_r11_spr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dma_spr_req |-> $past(commit_spr));

  a_r12_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    vram_re |=> !cpu_ready);

  a_r12_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vram_we, vram_re}));

endmodule

bind vidctl_host_port vhp_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .commit_data  (commit_data),
  .advance_read (advance_read),
  .stat_rd      (stat_rd),
  .commit_len   (commit_len),
  .commit_spr   (commit_spr),
  .evt_set      (evt_set),
  .waddr_q      (waddr_q),
  .raddr_q      (raddr_q),
  .stride       (stride),
  .status_byte  (status_byte),
  .irq          (irq),
  .vram_we      (vram_we),
  .vram_re      (vram_re),
  .cpu_ready    (cpu_ready),
  .dma_vram_req (dma_vram_req),
  .dma_spr_req  (dma_spr_req)
);

// File: tb/vidctl_host_port_test.sv
`timescale 1ns/1ps
module vidctl_host_port_test;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        cpu_sel, cpu_wr, cpu_rd;
  logic [1:0]  cpu_addr;
  logic [7:0]  cpu_wdata;
  logic [7:0]  cpu_rdata;
  logic        cpu_ready;
  logic [5:0]  evt_set;
  logic        irq;
  logic [14:0] vram_addr;
  logic        vram_we, vram_re;
  logic [15:0] vram_wdata;
  logic [15:0] vram_rdata;
  logic        dma_vram_req, dma_spr_req;
  logic [15:0] hscroll_cfg, vscroll_cfg, hsync_cfg, hdisp_cfg;
  logic [15:0] vsync_cfg, vdisp_cfg, vend_cfg;

  int n_chk = 0;
  int n_bad = 0;
  int we_cnt = 0;
  int len_pulses = 0;
  int spr_pulses = 0;
  bit done = 0;

  logic [15:0] mem [1024];

  vidctl_host_port uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .evt_set(evt_set), .irq(irq),
    .vram_addr(vram_addr), .vram_we(vram_we), .vram_re(vram_re),
    .vram_wdata(vram_wdata), .vram_rdata(vram_rdata),
    .dma_vram_req(dma_vram_req), .dma_spr_req(dma_spr_req),
    .hscroll_cfg(hscroll_cfg), .vscroll_cfg(vscroll_cfg),
    .hsync_cfg(hsync_cfg), .hdisp_cfg(hdisp_cfg), .vsync_cfg(vsync_cfg),
    .vdisp_cfg(vdisp_cfg), .vend_cfg(vend_cfg)
  );

  // Memory model: one-cycle read latency, low 10 address bits decoded.
  always @(posedge clk) begin
    if (vram_re) vram_rdata <= mem[vram_addr[9:0]];
    if (vram_we) begin
      mem[vram_addr[9:0]] <= vram_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (dma_vram_req) len_pulses <= len_pulses + 1;
    if (dma_spr_req)  spr_pulses <= spr_pulses + 1;
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_sel = 1; cpu_wr = 1; cpu_rd = 0; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 0; cpu_wr = 0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_sel = 1; cpu_wr = 0; cpu_rd = 1; cpu_addr = a;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_sel = 0; cpu_rd = 0;
  endtask

  task automatic set_reg(logic [4:0] idx, logic [15:0] v);
    bus_wr(2'd0, {3'b0, idx});
    bus_wr(2'd2, v[7:0]);
    bus_wr(2'd3, v[15:8]);
  endtask

  function automatic logic [15:0] stride_exp(int sel);
    return (sel == 0) ? 16'd1 : 16'd16 << sel;
  endfunction

  task automatic t_reset();
    logic [7:0] b;
    check("R2 hsync", hsync_cfg, 16'h00FF);
    check("R2 hdisp", hdisp_cfg, 16'h001F);
    check("R2 vsync", vsync_cfg, 16'hFFFF);
    check("R2 vdisp", vdisp_cfg, 16'h01FF);
    check("R2 vend",  vend_cfg,  16'hFFFF);
    check("R2 irq",   {15'd0, irq}, 16'd0);
    bus_rd(2'd2, b); check("R2 rbuf lo", {8'd0, b}, 16'h00FF);
    bus_rd(2'd3, b); check("R2 rbuf hi", {8'd0, b}, 16'h00FF);
    bus_rd(2'd0, b); check("R2 status", {8'd0, b}, 16'h0000);
  endtask

  task automatic t_select();
    set_reg(5'd13, 16'h1234);
    check("R1 full write", vdisp_cfg, 16'h1234);
    bus_wr(2'd0, 8'd11);
    bus_wr(2'd2, 8'h05);
    check("R1 low byte only", hdisp_cfg, 16'h0005);
    bus_wr(2'd3, 8'hA0);
    check("R1 high byte only", hdisp_cfg, 16'hA005);
    check("R1 other reg kept", vdisp_cfg, 16'h1234);
  endtask

  task automatic t_scroll();
    set_reg(5'd7, 16'hFFFF);
    check("R10 hscroll mask", hscroll_cfg, 16'h03FF);
    set_reg(5'd8, 16'hFFFF);
    check("R10 vscroll mask", vscroll_cfg, 16'h01FF);
  endtask

  task automatic t_write_stride(int sel);
    logic [15:0] d0, d1, nxt;
    d0 = 16'h1100 + 16'(sel);
    d1 = 16'h2200 + 16'(sel);
    nxt = 16'h0100 + stride_exp(sel);
    set_reg(5'd5, 16'(sel) << 11);
    set_reg(5'd0, 16'h0100);
    bus_wr(2'd0, 8'd2);
    bus_wr(2'd2, d0[7:0]); bus_wr(2'd3, d0[15:8]);
    bus_wr(2'd2, d1[7:0]); bus_wr(2'd3, d1[15:8]);
    @(negedge clk);
    check("R4 store first", mem[10'h100], d0);
    check("R3 stride store", mem[nxt[9:0]], d1);
  endtask

  task automatic t_read();
    logic [7:0] b;
    set_reg(5'd5, 16'h0000);
    set_reg(5'd1, 16'h0200);
    check("R12 ready low after fetch", {15'd0, cpu_ready}, 16'd0);
    @(negedge clk);
    check("R12 ready back", {15'd0, cpu_ready}, 16'd1);
    bus_wr(2'd0, 8'd2);
    bus_rd(2'd2, b); check("R6 fetched lo", {8'd0, b}, {8'd0, mem[10'h200][7:0]});
    bus_rd(2'd2, b); check("R7 lo read no effect", {8'd0, b}, {8'd0, mem[10'h200][7:0]});
    bus_rd(2'd3, b); check("R7 hi read", {8'd0, b}, {8'd0, mem[10'h200][15:8]});
    bus_rd(2'd2, b); check("R7 prefetch next lo", {8'd0, b}, {8'd0, mem[10'h201][7:0]});
    bus_rd(2'd3, b); check("R7 prefetch next hi", {8'd0, b}, {8'd0, mem[10'h201][15:8]});
    set_reg(5'd5, 16'h0800);
    bus_rd(2'd3, b);
    bus_rd(2'd2, b); check("R7 no step off index 2", {8'd0, b}, {8'd0, mem[10'h202][7:0]});
    bus_wr(2'd0, 8'd2);
    bus_rd(2'd3, b); check("R7 hi before stride 32", {8'd0, b}, {8'd0, mem[10'h202][15:8]});
    bus_rd(2'd2, b); check("R3 read stride 32", {8'd0, b}, {8'd0, mem[10'h222][7:0]});
    set_reg(5'd1, 16'h8300);
    bus_rd(2'd2, b); check("R6 address masked", {8'd0, b}, {8'd0, mem[10'h300][7:0]});
  endtask

  task automatic t_top_of_memory();
    int c0;
    logic [15:0] alias0;
    set_reg(5'd5, 16'h0000);
    set_reg(5'd0, 16'h7FFF);
    alias0 = mem[10'h000];
    c0 = we_cnt;
    bus_wr(2'd0, 8'd2);
    bus_wr(2'd2, 8'hCD); bus_wr(2'd3, 8'hAB);
    @(negedge clk);
    check("R4 last word stored", mem[10'h3FF], 16'hABCD);
    check("R4 one store", 16'(we_cnt - c0), 16'd1);
    bus_wr(2'd2, 8'h11); bus_wr(2'd3, 8'h11);
    @(negedge clk);
    check("R5 store suppressed", 16'(we_cnt - c0), 16'd1);
    check("R5 memory untouched", mem[10'h000], alias0);
  endtask

  task automatic t_dma();
    int l0, s0;
    l0 = len_pulses; s0 = spr_pulses;
    bus_wr(2'd0, 8'd18);
    bus_wr(2'd2, 8'h10);
    @(negedge clk);
    check("R11 no pulse on low byte", 16'(len_pulses - l0), 16'd0);
    bus_wr(2'd3, 8'h00);
    @(negedge clk);
    check("R11 vram dma pulse", 16'(len_pulses - l0), 16'd1);
    bus_wr(2'd0, 8'd19);
    bus_wr(2'd3, 8'h7F);
    @(negedge clk);
    check("R11 sprite dma pulse", 16'(spr_pulses - s0), 16'd1);
    check("R11 vram count unchanged", 16'(len_pulses - l0), 16'd1);
  endtask

  task automatic t_status();
    logic [7:0] b;
    @(negedge clk); evt_set = 6'b000100;
    @(negedge clk); evt_set = 6'b000000;
    check("R9 irq raised", {15'd0, irq}, 16'd1);
    bus_rd(2'd0, b); check("R9 raster bit", {8'd0, b}, 16'h0004);
    check("R8 irq dropped", {15'd0, irq}, 16'd0);
    bus_rd(2'd0, b); check("R8 status cleared", {8'd0, b}, 16'h0000);
    @(negedge clk); evt_set = 6'b100000;
    @(negedge clk); evt_set = 6'b000001;
    @(negedge clk); evt_set = 6'b000000;
    bus_rd(2'd0, b); check("R9 vblank and collision", {8'd0, b}, 16'h0021);
    bus_rd(2'd1, b); check("R8 port 1 zero", {8'd0, b}, 16'h0000);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h4000 ^ 16'(i * 37);
    vram_rdata = 16'h0000;
    cpu_sel = 0; cpu_wr = 0; cpu_rd = 0; cpu_addr = 0; cpu_wdata = 0;
    evt_set = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_select();
    t_scroll();
    for (int s = 0; s < 4; s++) t_write_stride(s);
    t_read();
    t_top_of_memory();
    t_dma();
    t_status();
    done = 1;
    finish_run();
  end

endmodule